// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block is the host side of a link to a three-wire serial sampling converter. It makes the convert strobe and the serial clock itself. It samples the converter's data line, and it hands each result to the rest of the chip as a 16-bit two's complement word together with a one-cycle valid strobe. One conversion is one frame of exactly 18 serial clocks. The first 16 clocks form the data window. The last two give the converter time to acquire its input before the next convert edge.

The serial clock comes from the system clock through a programmable divider. Each high or low phase lasts `div_half + 1` system cycles, and the divider value is taken when a frame is launched. The integrator picks `div_half` so that the serial clock period stays inside the converter's allowed window. A one-cycle `start` in idle runs one frame. Holding `run` high chains frames with no gap. The converter always returns the sample it took at the previous convert edge, so the first word after reset carries no fresh data and is marked stale. The result width, 12 or 14 bits, is a parameter. Only the leading bits of the data window are used, and the bits after them are discarded.

Top module: `adc_read_ctrl`

## Requirements
- R1: During reset and whenever no frame is in progress, `adc_sck`, `adc_conv` and `sample_valid` are low. `sample_stale` is low after reset.
- R2: One `start` pulse in idle gives exactly one frame of 18 rising `adc_sck` edges and then returns to idle. While `run` is high, the next frame's `adc_conv` rises on the same system edge as the previous frame's 18th falling `adc_sck` edge.
- R3: `adc_conv` rises while `adc_sck` is low, exactly DIV+1 system cycles before the frame's first rising `adc_sck` edge. It falls together with the first falling `adc_sck` edge.
- R4: Every `adc_sck` high phase, and every low phase inside a frame, lasts DIV+1 system cycles. DIV is the `div_half` value present at the system edge that launches the frame. A change of `div_half` during a frame takes effect only in the next frame.
- R5: The bit the converter drives after rising `adc_sck` edge n is sampled on rising edge n+1. The RES_BITS data bits arrive MSB first and are sampled on rising edges 2 through RES_BITS+1 of the frame. Data-line values after the last data bit do not affect the result.
- R6: `sample` holds the received RES_BITS-bit two's complement code, sign-extended to 16 bits.
- R7: `sample_valid` is high for exactly one system cycle. It rises on the same system edge that produces rising `adc_sck` edge RES_BITS+1. `sample` does not change while `sample_valid` is low.
- R8: `sample_stale` is high together with the first `sample_valid` after reset and low with every later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one frame when sampled high in idle |
| run | input | 1 | While high, frames repeat back to back |
| div_half | input | DIV_W | Serial clock half-period minus one, in system cycles |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| sample | output | 16 | Sign-extended result word |
| sample_valid | output | 1 | One-cycle strobe marking a new `sample` |
| sample_stale | output | 1 | Qualifies `sample_valid`: word precedes any real conversion |

## Verification
Every output of this block comes from a register that is loaded on the same system edge as the serial clock transition that caused it. The convert strobe therefore appears one cycle after the launching edge. The valid strobe and the new word appear in the same cycle as rising serial edge RES_BITS+1, and each serial phase is due DIV+1 cycles after the previous one. The bench samples every output on the falling system clock edge and counts serial edges there. It recovers DIV from the value `div_half` held just before the launching edge and compares every cycle against these counts. A converter model with the previous-sample behaviour drives the data line a short delay after each rising serial edge and loads junk into the positions after the data bits. Two instances, 14-bit and 12-bit, run side by side.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    // serial clocks in one conversion frame: 16 data plus 2 acquisition
    localparam int SCK_PER_FRAME = 18;
    localparam int OUT_W         = 16;
    localparam int IDX_W         = $clog2(SCK_PER_FRAME);

    typedef logic [IDX_W-1:0] sck_idx_t;

    typedef enum logic {
        ST_IDLE,
        ST_FRAME
    } frame_st_t;

    // edge enables: the serial clock changes on the coming system edge
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    // replicate bit nbits-1 into every position above it
    function automatic logic [OUT_W-1:0] sign_ext(input logic [OUT_W-1:0] raw,
                                                  input int nbits);
        logic [OUT_W-1:0] ext;
        for (int i = 0; i < OUT_W; i++) begin
            ext[i] = (i < nbits) ? raw[i] : raw[nbits-1];
        end
        return ext;
    endfunction

endpackage

// File: rtl/adcrd_sck_gen.sv
module adcrd_sck_gen
    import adcrd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    output logic             sck,
    output sck_edge_t        edge_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] hc_q;
    logic [DIV_W-1:0] ph_cnt;
    logic             sck_q;
    logic             tick;

    assign tick        = en && (hc_q == '0);
    assign edge_o.rise = tick && !sck_q;
    assign edge_o.fall = tick && sck_q;
    assign sck         = sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            hc_q  <= '0;
            sck_q <= 1'b0;
        end else if (load) begin
            div_q <= div_in;
            hc_q  <= div_in;
            sck_q <= 1'b0;
        end else if (!en) begin
            sck_q <= 1'b0;
        end else if (tick) begin
            hc_q  <= div_q;
            sck_q <= ~sck_q;
        end else begin
            hc_q  <= hc_q - 1'b1;
        end
    end

    // phase age counted upward, independent of the reload counter
    always_ff @(posedge clk) begin
        if (rst || load || tick) begin
            ph_cnt <= '0;
        end else if (en) begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    // R4
    sck_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_o.rise || edge_o.fall) |-> (ph_cnt == div_q));

endmodule

// File: rtl/adcrd_frame_seq.sv
module adcrd_frame_seq
    import adcrd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      run,
    input  sck_edge_t edge_i,
    output logic      load,
    output logic      active,
    output logic      conv,
    output sck_idx_t  idx
);

    localparam sck_idx_t LAST_IDX = sck_idx_t'(SCK_PER_FRAME - 1);

    frame_st_t st_q;
    sck_idx_t  idx_q;
    logic      conv_q;
    logic      last_fall;

    assign last_fall = (st_q == ST_FRAME) && edge_i.fall && (idx_q == LAST_IDX);
    assign load      = ((st_q == ST_IDLE) && (start || run)) || (last_fall && run);
    assign active    = (st_q == ST_FRAME);
    assign conv      = conv_q;
    assign idx       = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            conv_q <= 1'b0;
        end else if (load) begin
            st_q   <= ST_FRAME;
            idx_q  <= '0;
            conv_q <= 1'b1;
        end else if ((st_q == ST_FRAME) && edge_i.fall) begin
            if (idx_q == '0) begin
                conv_q <= 1'b0;
            end
            if (idx_q == LAST_IDX) begin
                st_q  <= ST_IDLE;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_IDX);

endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture
    import adcrd_pkg::*;
#(
    parameter int RES_BITS = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  sck_edge_t        edge_i,
    input  sck_idx_t         idx,
    input  logic             sdo,
    output logic [OUT_W-1:0] sample,
    output logic             valid,
    output logic             stale
);

    localparam sck_idx_t FIRST_IDX = sck_idx_t'(1);
    localparam sck_idx_t LAST_IDX  = sck_idx_t'(RES_BITS);

    logic [RES_BITS-1:0] sh_q;
    logic [RES_BITS-1:0] sh_next;
    logic [OUT_W-1:0]    sample_q;
    logic                valid_q;
    logic                stale_q;
    logic                seen_q;
    logic                in_win;
    logic                done;

    assign in_win  = edge_i.rise && (idx >= FIRST_IDX) && (idx <= LAST_IDX);
    assign done    = edge_i.rise && (idx == LAST_IDX);
    assign sh_next = {sh_q[RES_BITS-2:0], sdo};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            sample_q <= '0;
            valid_q  <= 1'b0;
            stale_q  <= 1'b0;
            seen_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (in_win) begin
                sh_q <= sh_next;
            end
            if (done) begin
                sample_q <= sign_ext(OUT_W'(sh_next), RES_BITS);
                valid_q  <= 1'b1;
                stale_q  <= !seen_q;
                seen_q   <= 1'b1;
            end
        end
    end

    assign sample = sample_q;
    assign valid  = valid_q;
    assign stale  = stale_q;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R7
    sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(sample_q));

    // R6
    sext_fill_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ((sample_q[OUT_W-1:RES_BITS-1] == '0) ||
                     (sample_q[OUT_W-1:RES_BITS-1] == '1)));

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adcrd_pkg::*;
#(
    parameter int RES_BITS = 14,
    parameter int DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    input  logic             adc_sdo,
    output logic             adc_conv,
    output logic             adc_sck,
    output logic [OUT_W-1:0] sample,
    output logic             sample_valid,
    output logic             sample_stale
);

    sck_edge_t sck_edge;
    sck_idx_t  frame_idx;
    logic      frame_load;
    logic      frame_active;

    adcrd_frame_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .run    (run),
        .edge_i (sck_edge),
        .load   (frame_load),
        .active (frame_active),
        .conv   (adc_conv),
        .idx    (frame_idx)
    );

    adcrd_sck_gen #(
        .DIV_W (DIV_W)
    ) u_sck (
        .clk    (clk),
        .rst    (rst),
        .en     (frame_active),
        .load   (frame_load),
        .div_in (div_half),
        .sck    (adc_sck),
        .edge_o (sck_edge)
    );

    adcrd_capture #(
        .RES_BITS (RES_BITS)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .edge_i (sck_edge),
        .idx    (frame_idx),
        .sdo    (adc_sdo),
        .sample (sample),
        .valid  (sample_valid),
        .stale  (sample_stale)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_active |-> (!adc_sck && !adc_conv && !sample_valid));

    // R3
    conv_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_conv) |-> !adc_sck);

    // R3
    conv_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_conv) |-> $fell(adc_sck));

    // R7
    valid_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (frame_active && adc_sck));

endmodule

// File: tb/tb_adc_read_ctrl.sv
module tb_adc_lane #(
    parameter int RES = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        conv,
    input  logic        sck,
    input  logic [15:0] sample,
    input  logic        valid,
    input  logic        stale,
    input  logic [7:0]  div_in,
    output logic        sdo,
    output int          nchk,
    output int          nerr,
    output int          rises
);

    // ---------------- converter model ----------------
    int exp_w[$];
    bit exp_s[$];
    int held_cur = 'h155;
    int kk = 0;
    bit first_conv = 1'b1;
    int adc_rn = 0;
    int out_word = 0;
    int pos = 0;

    initial sdo = 1'b0;

    function automatic int pick(int k);
        int mask;
        mask = (1 << RES) - 1;
        case (k % 6)
            0: return 1 << (RES - 1);
            1: return mask >> 1;
            2: return mask;
            3: return 0;
            4: return 1;
            default: return (k * 1237 + 91) & mask;
        endcase
    endfunction

    // result of this frame is the sample held at the previous convert edge
    always @(posedge conv) begin
        exp_w.push_back(held_cur);
        exp_s.push_back(first_conv);
        first_conv = 1'b0;
        out_word   = held_cur;
        held_cur   = pick(kk);
        kk++;
        adc_rn     = 0;
    end

    always @(posedge sck) begin
        adc_rn++;
        pos = adc_rn - 1;
        #1;
        if (pos < RES) sdo = 1'((out_word >> (RES - 1 - pos)) & 1);
        else           sdo = 1'(pos & 1) ^ 1'b1;
    end

    // ---------------- reference checks ----------------
    bit ps, pc;
    int rn, len, c2r, div_l, frames, last_s, div_prev;

    task automatic chk(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s res=%0d actual=%0d expected=%0d at %0t", req, RES, act, expv, $time);
        end
    endtask

    initial begin
        nchk = 0; nerr = 0; rises = 0;
    end

    always @(negedge clk) begin
        bit rise_e, fall_e, crise, cfall, ev;
        int w, sv;
        if (rst) begin
            ps = 0; pc = 0; rn = 0; len = 0; c2r = 0; frames = 0;
            last_s = 0; div_l = 0;
        end else begin
            rise_e = sck && !ps;
            fall_e = !sck && ps;
            crise  = conv && !pc;
            cfall  = !conv && pc;
            // phase lengths, judged against the divider of the running frame
            if (sck != ps) begin
                if (ps) chk(len == div_l + 1, "R4 high phase", len, div_l + 1);
                else if (rn >= 1) chk(len == div_l + 1, "R4 low phase", len, div_l + 1);
                len = 1;
            end else begin
                len++;
            end
            if (crise) begin
                if (frames > 0) chk(rn == 18, "R2 rises per frame", rn, 18);
                chk(!sck, "R3 convert while clock low", int'(sck), 0);
                rn = 0;
                frames++;
                div_l = div_prev;
                c2r = 1;
            end
            if (rise_e) begin
                if (rn == 0) chk(c2r == div_l + 1, "R3 convert lead", c2r, div_l + 1);
                rn++;
                rises++;
            end else if (conv && !crise) begin
                c2r++;
            end
            if (cfall) chk(fall_e && rn == 1, "R3 convert drop", rn, 1);
            ev = rise_e && (rn == RES + 1);
            chk(valid == ev, "R7 valid timing", int'(valid), int'(ev));
            if (valid && ev) begin
                if (exp_w.size() == 0) begin
                    chk(1'b0, "R5 no expected word", 0, 1);
                end else begin
                    w  = exp_w.pop_front();
                    sv = (w >= (1 << (RES - 1))) ? w - (1 << RES) : w;
                    chk(int'($signed(sample)) == sv, "R5 R6 sample value", int'($signed(sample)), sv);
                    chk(stale == exp_s.pop_front(), "R8 stale flag", int'(stale), int'(!stale));
                end
                last_s = int'(sample);
            end else if (!valid) begin
                chk(int'(sample) == last_s, "R7 sample hold", int'(sample), last_s);
            end
            ps = sck;
            pc = conv;
        end
        div_prev = int'(div_in);
    end

endmodule

module tb_adc_read_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  div_half = 8'd1;
    logic        sdo14, sdo12;
    logic        conv14, conv12, sck14, sck12;
    logic [15:0] smp14, smp12;
    logic        val14, val12, stl14, stl12;
    int          c14, e14, r14, c12, e12, r12;
    int          own_chk = 0;
    int          own_err = 0;
    bit          done = 1'b0;
    bit          reported = 1'b0;

    always #2 clk = ~clk;

    adc_read_ctrl #(.RES_BITS(14), .DIV_W(8)) dut (
        .clk(clk), .rst(rst), .start(start), .run(run), .div_half(div_half),
        .adc_sdo(sdo14), .adc_conv(conv14), .adc_sck(sck14),
        .sample(smp14), .sample_valid(val14), .sample_stale(stl14)
    );

    adc_read_ctrl #(.RES_BITS(12), .DIV_W(8)) dut12 (
        .clk(clk), .rst(rst), .start(start), .run(run), .div_half(div_half),
        .adc_sdo(sdo12), .adc_conv(conv12), .adc_sck(sck12),
        .sample(smp12), .sample_valid(val12), .sample_stale(stl12)
    );

    tb_adc_lane #(.RES(14)) lane14 (
        .clk(clk), .rst(rst), .conv(conv14), .sck(sck14), .sample(smp14),
        .valid(val14), .stale(stl14), .div_in(div_half), .sdo(sdo14),
        .nchk(c14), .nerr(e14), .rises(r14)
    );

    tb_adc_lane #(.RES(12)) lane12 (
        .clk(clk), .rst(rst), .conv(conv12), .sck(sck12), .sample(smp12),
        .valid(val12), .stale(stl12), .div_in(div_half), .sdo(sdo12),
        .nchk(c12), .nerr(e12), .rises(r12)
    );

    task automatic tchk(bit ok, string req, int act, int expv);
        own_chk++;
        if (!ok) begin
            own_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // inputs change just after a rising edge
    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic check_idle(string req);
        look();
        tchk(!sck14 && !sck12, {req, " clock idle low"}, int'(sck14 | sck12), 0);
        tchk(!conv14 && !conv12, {req, " convert idle low"}, int'(conv14 | conv12), 0);
        tchk(!val14 && !val12, {req, " valid idle low"}, int'(val14 | val12), 0);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", own_chk + c14 + c12, own_err + e14 + e12);
            $finish;
        end
    endtask

    initial begin
        int base14, base12;
        step(5);
        rst = 1'b0;
        // R1 reset state
        check_idle("R1");
        tchk(!stl14 && !stl12, "R1 stale low after reset", int'(stl14 | stl12), 0);

        // R2 single frame from a start pulse, divider 1
        base14 = r14; base12 = r12;
        step(1); start = 1'b1;
        step(1); start = 1'b0;
        step(18 * 2 * 2 + 30);
        tchk(r14 - base14 == 18, "R2 single frame rises (14)", r14 - base14, 18);
        tchk(r12 - base12 == 18, "R2 single frame rises (12)", r12 - base12, 18);
        check_idle("R1 after frame");

        // fastest divider, one frame
        div_half = 8'd0;
        step(1); start = 1'b1;
        step(1); start = 1'b0;
        step(18 * 2 + 20);
        check_idle("R1 after fast frame");

        // R2 back-to-back frames, divider changed mid-frame (R4)
        div_half = 8'd2;
        run = 1'b1;
        step(18 * 2 * 3 * 4 + 50);
        div_half = 8'd3;
        step(18 * 2 * 4 * 4);
        run = 1'b0;
        step(18 * 2 * 4 + 30);
        check_idle("R1 after run");

        // R5 R6 more words across the code patterns, slower clock
        div_half = 8'd4;
        run = 1'b1;
        step(18 * 2 * 5 * 8 + 7);
        run = 1'b0;
        step(18 * 2 * 5 + 30);
        check_idle("R1 final");
        done = 1'b1;
        report();
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            own_chk++;
            own_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
        end
    end

endmodule